// File: doc/BRIEF.md
# Serial/Parallel Gain Control Register

This block holds the 9-bit setting of a programmable gain stage. The setting is made of a gain-or-attenuate select bit, a 4-bit coarse code and a 4-bit fine code. In serial mode a host clocks the word in one bit at a time on a slow shift clock, then pulses a load strobe. The load strobe copies the shift register into a holding register, and that holding register drives the gain outputs. A separate read strobe copies the held word back into the shift register. The host can then clock the word out on a serial output.

In parallel mode the gain outputs follow a 9-bit parallel input directly. The serial machinery is then frozen. The host pins (shift clock, data, strobes, mode) are slow and asynchronous. A fast system clock synchronises them and detects their edges. All state is static and holds for as long as no event arrives.

With the fine bits at zero, each coarse step is 1.5 dB, spanning 0 to 22.5 dB. The select bit decides whether that amount is applied as gain or as attenuation. The decoding itself happens outside this block.

Top module: `gain_ctrl_reg`

## Requirements
- R1: After reset, the held word and the shift register are all zeros. In serial mode `gain_word` reads 0 and `sdout` reads 0.
- R2: In serial mode, `sdin` is sampled on each rising edge of `sclk`. After nine rising edges and a rising edge of `ld_stb`, `gain_word[i]` equals the i-th bit shifted in (i = 0 first). The field layout is: [3:0] fine code (F0..F3), [7:4] coarse code (C0..C3), and [8] the gain/attenuate select.
- R3: `gain_word` changes in serial mode only on a rising edge of `ld_stb`. Shifting new data leaves it unchanged.
- R4: A rising edge of `rd_stb` while `sclk` is low loads the held word into the shift register. `sdout` then shows bit 0 of the held word before any falling edge of `sclk`.
- R5: After a readback load, each falling edge of `sclk` advances `sdout` by one bit. After k falling edges, `sdout` shows bit k of the held word.
- R6: A rising edge of `rd_stb` while `sclk` is high is ignored, and the shift register keeps its contents.
- R7: While `ser_mode` is 0, `gain_word` equals `par_word`. Shift-clock and strobe events are ignored, so after a return to serial mode `gain_word` again shows the word held before.
- R8: A partly shifted word is kept across an arbitrarily long idle gap, and shifting continues from where it stopped.
- R9: When a load strobe edge and an `sclk` rising edge fall in the same cycle, the held word takes the pre-shift contents. When load and read strobe edges coincide, the two registers exchange contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_mode | input | 1 | 1 selects serial mode, 0 selects parallel bypass |
| sclk | input | 1 | Asynchronous shift clock |
| sdin | input | 1 | Serial data input, sampled on sclk rising |
| ld_stb | input | 1 | Load strobe: shift register to held word |
| rd_stb | input | 1 | Read strobe: held word to shift register |
| par_word | input | 9 | Parallel gain word used in parallel mode |
| gain_word | output | 9 | Gain setting driven to the analog stage |
| sdout | output | 1 | Serial readback output |

## Verification
Two pairs of functions can meet in one synchronised cycle. The first pair is a load strobe edge and a shift-clock rising edge. The second pair is a load strobe edge and a read strobe edge. The bench provokes each by changing both pins in the same time step, so the synchronisers present both edges in the same cycle. It judges the first pair by checking that the held word equals the word before the shift, and that a second, lone load then shows the shifted word. It judges the second pair by checking that the held word becomes the old shift contents, and that a following load brings back the old held word.

// File: rtl/gain_ctrl_pkg.sv
// Package: shared widths and field layout of the 9-bit gain control word.
// Assumes bit 0 is the first bit shifted in (fine LSB).
package gain_ctrl_pkg;
    localparam int FINE_W   = 4;
    localparam int COARSE_W = 4;
    localparam int WORD_W   = FINE_W + COARSE_W + 1;
    localparam int PIN_W    = 5;   // synchronised host pins

    // Pin positions inside the synchronised bundle
    localparam int P_SCLK = 0;
    localparam int P_DIN  = 1;
    localparam int P_LD   = 2;
    localparam int P_RD   = 3;
    localparam int P_MODE = 4;

    typedef logic [WORD_W-1:0] gword_t;

    typedef struct packed {
        logic                atten;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } gfields_t;
endpackage

// File: rtl/gcr_sync.sv
// Module: multi-stage synchroniser with one extra history stage per bit.
// Assumes inputs are slow compared with clk; edges are found by comparing
// the synchronised level with the history stage.
module gcr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [DEPTH-1:0] chain;

        // Shift each pin through its synchroniser and history stages
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[DEPTH-2:0], d_async[b]};
        end

        assign lvl[b]  = chain[STAGES-1];
        assign prev[b] = chain[STAGES];
    end
endmodule

// File: rtl/gcr_core.sv
// Module: shift register, held word and serial output register.
// Assumes single-cycle event pulses from the synchroniser; all events are
// gated off while the synchronised mode bit selects parallel operation.
module gcr_core
    import gain_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_ser,
    input  logic   sclk_lvl,
    input  logic   sclk_prev,
    input  logic   din_lvl,
    input  logic   ld_lvl,
    input  logic   ld_prev,
    input  logic   rd_lvl,
    input  logic   rd_prev,
    output gword_t held_q,
    output logic   sdout_q
);
    gword_t sr_q;
    logic   sclk_rise, sclk_fall, ld_ev, rd_raw, rd_ev;

    // Event decode from synchronised levels
    always_comb begin
        sclk_rise = mode_ser &&  sclk_lvl && !sclk_prev;
        sclk_fall = mode_ser && !sclk_lvl &&  sclk_prev;
        ld_ev     = mode_ser &&  ld_lvl   && !ld_prev;
        rd_raw    = mode_ser &&  rd_lvl   && !rd_prev;
        rd_ev     = rd_raw && !sclk_lvl;
    end

    // Shift register: readback load has priority over a serial shift
    always_ff @(posedge clk) begin
        if (!rst_n)         sr_q <= '0;
        else if (rd_ev)     sr_q <= held_q;
        else if (sclk_rise) sr_q <= {din_lvl, sr_q[WORD_W-1:1]};
    end

    // Held word: captures the shift register on a load strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n)     held_q <= '0;
        else if (ld_ev) held_q <= sr_q;
    end

    // Serial output: first bit on readback load, next bit on sclk falling
    always_ff @(posedge clk) begin
        if (!rst_n)         sdout_q <= 1'b0;
        else if (rd_ev)     sdout_q <= held_q[0];
        else if (sclk_fall) sdout_q <= sr_q[0];
    end

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ev |=> $stable(held_q));
    assert_readback_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ev |=> sdout_q == $past(held_q[0]));
    assert_sdout_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !rd_ev) |=> sdout_q == $past(sr_q[0]));
    assert_lato_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_raw && sclk_lvl && !sclk_rise) |=> $stable(sr_q));
    assert_ld_preshift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ev && sclk_rise) |=> held_q == $past(sr_q));
endmodule

// File: rtl/gain_ctrl_reg.sv
// Module: top of the serial/parallel gain control register.
// Assumes host pins are asynchronous and much slower than clk; the output
// bypass in parallel mode is combinational from the pins.
module gain_ctrl_reg
    import gain_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              ld_stb,
    input  logic              rd_stb,
    input  logic [WORD_W-1:0] par_word,
    output logic [WORD_W-1:0] gain_word,
    output logic              sdout
);
    logic [PIN_W-1:0] pins, lvl, prev;
    gword_t           held;
    gfields_t         sel;

    // Bundle the host pins for the synchroniser
    always_comb begin
        pins         = '0;
        pins[P_SCLK] = sclk;
        pins[P_DIN]  = sdin;
        pins[P_LD]   = ld_stb;
        pins[P_RD]   = rd_stb;
        pins[P_MODE] = ser_mode;
    end

    gcr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pins),
        .lvl    (lvl),
        .prev   (prev)
    );

    gcr_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_ser (lvl[P_MODE]),
        .sclk_lvl (lvl[P_SCLK]),
        .sclk_prev(prev[P_SCLK]),
        .din_lvl  (lvl[P_DIN]),
        .ld_lvl   (lvl[P_LD]),
        .ld_prev  (prev[P_LD]),
        .rd_lvl   (lvl[P_RD]),
        .rd_prev  (prev[P_RD]),
        .held_q   (held),
        .sdout_q  (sdout)
    );

    // Output select: held word in serial mode, parallel pins otherwise
    always_comb begin
        sel       = ser_mode ? gfields_t'(held) : gfields_t'(par_word);
        gain_word = gword_t'(sel);
    end
endmodule

// File: tb/tb_gain_ctrl_reg.sv
module tb_gain_ctrl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic       ld_stb = 1'b0, rd_stb = 1'b0;
    logic [8:0] par_word = '0;
    logic [8:0] gain_word;
    logic       sdout;
    int         total = 0, fails = 0;

    always #4 clk = ~clk;

    gain_ctrl_reg dut (.clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .sclk(sclk),
        .sdin(sdin), .ld_stb(ld_stb), .rd_stb(rd_stb), .par_word(par_word),
        .gain_word(gain_word), .sdout(sdout));

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sdin = b; gap(4); sclk = 1'b1; gap(4); sclk = 1'b0; gap(4);
    endtask

    task automatic shift_word(input logic [8:0] w);
        for (int i = 0; i < 9; i++) shift_bit(w[i]);
    endtask

    task automatic pulse_ld();
        ld_stb = 1'b1; gap(4); ld_stb = 1'b0; gap(4);
    endtask

    task automatic read_check(input logic [8:0] w, input string tag);
        logic [8:0] got;
        sdin = 1'b0;
        rd_stb = 1'b1; gap(4); rd_stb = 1'b0; gap(4);
        got = '0; got[0] = sdout;
        for (int k = 1; k < 9; k++) begin
            sclk = 1'b1; gap(4); sclk = 1'b0; gap(4);
            got[k] = sdout;
        end
        chk(got, w, tag);
    endtask

    function automatic logic [8:0] shr_in(input logic [8:0] w, input logic b);
        return {b, w[8:1]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [8:0] a, p, prevw;
        logic [31:0] r;
        void'($urandom(32'h5eed));
        gap(5); rst_n = 1'b1; gap(6);

        // R1 reset state
        chk(gain_word, 9'h000, "R1 gain after reset");
        chk({8'h0, sdout}, 9'h000, "R1 sdout after reset");
        read_check(9'h000, "R1 readback zeros");

        // R2 directed: coarse code 15, attenuate set, fine zero
        shift_word(9'h1F0); pulse_ld();
        chk(gain_word, 9'h1F0, "R2 directed word");
        prevw = 9'h1F0;

        // R2 R3 R4 R5 random words
        for (int it = 0; it < 12; it++) begin
            r = $urandom(); a = r[8:0];
            shift_word(a);
            chk(gain_word, prevw, "R3 gain held while shifting");
            pulse_ld();
            chk(gain_word, a, "R2 random word loaded");
            if (it < 4) begin
                sdin = 1'b0; rd_stb = 1'b1; gap(4); rd_stb = 1'b0; gap(4);
                chk({8'h0, sdout}, {8'h0, a[0]}, "R4 first bit before falling edge");
                for (int k = 1; k < 9; k++) begin
                    sclk = 1'b1; gap(4); sclk = 1'b0; gap(4);
                    chk({8'h0, sdout}, {8'h0, a[k]}, "R5 bit after falling edge");
                end
            end else begin
                read_check(a, "R4 R5 readback word");
            end
            prevw = a;
        end

        // R6 read strobe while sclk high is ignored
        shift_word(9'h0A5); pulse_ld();        // held = 0A5
        shift_word(9'h13C);                    // sr = 13C
        sdin = 1'b0; sclk = 1'b1; gap(4);      // one extra shift of 0
        rd_stb = 1'b1; gap(4); rd_stb = 1'b0; gap(4);
        sclk = 1'b0; gap(4);
        pulse_ld();
        chk(gain_word, shr_in(9'h13C, 1'b0), "R6 ignored read strobe");

        // R7 parallel bypass and events ignored
        prevw = gain_word;
        ser_mode = 1'b0; par_word = 9'h155; gap(6);
        chk(gain_word, 9'h155, "R7 bypass value");
        par_word = 9'h0CA; gap(1);
        chk(gain_word, 9'h0CA, "R7 bypass follows pins");
        shift_word(9'h1FF); pulse_ld();
        ser_mode = 1'b1; gap(6);
        chk(gain_word, prevw, "R7 held word kept");
        pulse_ld();
        chk(gain_word, shr_in(9'h13C, 1'b0), "R7 shift register untouched");

        // R8 long idle gap mid-word
        a = 9'h0B7;
        for (int i = 0; i < 5; i++) shift_bit(a[i]);
        gap(3000);
        for (int i = 5; i < 9; i++) shift_bit(a[i]);
        pulse_ld();
        chk(gain_word, a, "R8 word across idle gap");

        // R9 load strobe with sclk rising in the same cycle
        a = 9'h06D;
        shift_word(a);
        sdin = 1'b1; gap(4);
        sclk = 1'b1; ld_stb = 1'b1; gap(4);
        sclk = 1'b0; ld_stb = 1'b0; gap(4);
        chk(gain_word, a, "R9 load takes pre-shift word");
        pulse_ld();
        chk(gain_word, shr_in(a, 1'b1), "R9 shift happened too");

        // R9 load and read strobes together swap contents
        a = gain_word;
        p = 9'h112;
        shift_word(p);
        ld_stb = 1'b1; rd_stb = 1'b1; gap(4);
        ld_stb = 1'b0; rd_stb = 1'b0; gap(4);
        chk(gain_word, p, "R9 swap held gets shift word");
        pulse_ld();
        chk(gain_word, a, "R9 swap shift gets held word");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule